// File: doc/BRIEF.md
# Command-Driven Parallel Flash Device Model

This block is the device side of a byte-wide parallel NOR flash that is controlled entirely by bus writes. A host writes command bytes over a synchronous bus with address, write data and separate write and read strobes. The last command decides what a read returns. It can return the stored array byte, identification codes and lock bits, or a status byte. Program, block erase and the clearing of all block protection are two-write sequences. The first write sets up the operation. The second write supplies the data or the confirm byte.

Storage is a small register array split into equal blocks, each with its own protection bit. A strap input acts as a master lockdown. While an accepted operation runs, a parameterised countdown holds the device busy. During that time every read returns the status byte and every write is dropped. When an operation finishes or is rejected, the device is left showing status, so a host can poll the ready bit and the error flags.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset every array byte reads 0xFF, the read view is the array, the status byte is 0x80 and each block's protection bit equals the matching bit of BLK_LOCK_INIT.
- R2: Writing 0xFF selects the array view, in which a read at an address returns the byte stored there.
- R3: Writing 0x90 selects the identifier view. Address 0 returns MFR_CODE and address 1 returns DEV_CODE. Address 3 returns 0x01 when the master lock strap is high and 0x00 otherwise. Any other address whose offset within its block is 2 returns 0x01 when that block is protected and 0x00 otherwise. All remaining addresses return 0x00.
- R4: Writing 0x70 selects the status view. The status byte has bit 7 = ready, bit 5 = erase error, bit 4 = program error and bit 1 = protection abort. Bits 6, 3, 2 and 0 read 0.
- R5: Writing 0x40 and then a data byte to an address in an unprotected block stores old AND data at that address.
- R6: Writing 0x20 and then 0xD0 sets every byte of the block that holds the confirm address to 0xFF. Other blocks are left unchanged.
- R7: Writing 0x60 and then 0xD0 clears every block protection bit when the master lock strap is low. When the strap is high, it sets bits 5 and 1 and leaves the protection bits unchanged.
- R8: A program aimed at a protected block sets bits 4 and 1. An erase aimed at a protected block sets bits 5 and 1. Neither changes the array or starts a busy period.
- R9: An erase or unlock setup followed by any byte other than 0xD0 sets bits 5 and 1 and changes neither the array nor the protection bits.
- R10: Writing 0x50 clears status bits 5, 4 and 1 and leaves the read view unchanged.
- R11: An accepted program, erase or unlock holds bit 7 low for BUSY_CYCLES read edges after the confirming write edge. During that time every read returns the status byte and every write is ignored.
- R12: After a program, erase or unlock sequence, whether it completes or is rejected, the read view is status.
- R13: rdData is registered. It updates only on an edge with rdEn high, and it reflects the view and contents in force before any write taken on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterLock | input | 1 | Lockdown strap; when high, the protection bits cannot be cleared |
| addr | input | ADDR_W | Byte address for reads and writes |
| wrData | input | 8 | Command, confirm or program data byte |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Registered read result |

## Verification
A read and a command write can land on the same clock edge. Likewise, the last busy cycle can meet a new command. The bench drives a read of a programmed byte on the same edge as an identifier command and expects the array byte back, not an identifier value. It then expects the identifier view on the next read. It also writes an identifier command in the cycle right after a program confirm, while the device is busy. It then checks that the command was dropped: the polled read after completion still shows status.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLRSTAT = 8'h50;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_UNLOCK  = 8'h60;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;

  // status byte bit positions
  localparam int ST_READY = 7;
  localparam int ST_ERASE = 5;
  localparam int ST_PROG  = 4;
  localparam int ST_ABORT = 1;

  typedef enum logic [1:0] {
    VIEW_ARRAY  = 2'd0,
    VIEW_ID     = 2'd1,
    VIEW_STATUS = 2'd2
  } view_e;

  typedef enum logic [2:0] {
    M_ARRAY  = 3'd0,
    M_ID     = 3'd1,
    M_STATUS = 3'd2,
    M_PROG   = 3'd3,
    M_ERASE  = 3'd4,
    M_UNLOCK = 3'd5
  } mode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic  prog;
    logic  erase;
    logic  clrLocks;
    view_e view;
  } fcStrobe_t;

endpackage

// File: rtl/fc_control.sv
module fc_control
  import flashcmd_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       masterLock,
  input  logic       targetLocked,
  output fcStrobe_t  strb,
  output logic [7:0] statusByte
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  mode_e            mode, nextMode;
  logic [CNT_W-1:0] busyCnt;
  logic             busy, accept;
  logic             errErase, errProg, errAbort;
  logic             setErase, setProg, setAbort, clrErr, startBusy;

  assign busy   = (busyCnt != '0);
  assign accept = wrEn && !busy;

  always_comb begin
    nextMode      = mode;
    strb.prog     = 1'b0;
    strb.erase    = 1'b0;
    strb.clrLocks = 1'b0;
    setErase      = 1'b0;
    setProg       = 1'b0;
    setAbort      = 1'b0;
    clrErr        = 1'b0;
    startBusy     = 1'b0;
    if (accept) begin
      case (mode)
        M_PROG: begin
          nextMode = M_STATUS;
          if (targetLocked) begin
            setProg  = 1'b1;
            setAbort = 1'b1;
          end else begin
            strb.prog = 1'b1;
            startBusy = 1'b1;
          end
        end
        M_ERASE: begin
          nextMode = M_STATUS;
          if (wrData != CMD_CONFIRM || targetLocked) begin
            setErase = 1'b1;
            setAbort = 1'b1;
          end else begin
            strb.erase = 1'b1;
            startBusy  = 1'b1;
          end
        end
        M_UNLOCK: begin
          nextMode = M_STATUS;
          if (wrData != CMD_CONFIRM || masterLock) begin
            setErase = 1'b1;
            setAbort = 1'b1;
          end else begin
            strb.clrLocks = 1'b1;
            startBusy     = 1'b1;
          end
        end
        default: begin
          case (wrData)
            CMD_ARRAY:   nextMode = M_ARRAY;
            CMD_IDENT:   nextMode = M_ID;
            CMD_STATUS:  nextMode = M_STATUS;
            CMD_CLRSTAT: clrErr   = 1'b1;
            CMD_PROG:    nextMode = M_PROG;
            CMD_ERASE:   nextMode = M_ERASE;
            CMD_UNLOCK:  nextMode = M_UNLOCK;
            default:     nextMode = mode;
          endcase
        end
      endcase
    end
  end

  always_comb begin
    if (busy) strb.view = VIEW_STATUS;
    else begin
      case (mode)
        M_ARRAY: strb.view = VIEW_ARRAY;
        M_ID:    strb.view = VIEW_ID;
        default: strb.view = VIEW_STATUS;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode     <= M_ARRAY;
      busyCnt  <= '0;
      errErase <= 1'b0;
      errProg  <= 1'b0;
      errAbort <= 1'b0;
    end else begin
      mode <= nextMode;
      if (startBusy)  busyCnt <= CNT_W'(BUSY_CYCLES);
      else if (busy)  busyCnt <= busyCnt - 1'b1;
      if (clrErr) begin
        errErase <= 1'b0;
        errProg  <= 1'b0;
        errAbort <= 1'b0;
      end else begin
        if (setErase) errErase <= 1'b1;
        if (setProg)  errProg  <= 1'b1;
        if (setAbort) errAbort <= 1'b1;
      end
    end
  end

  always_comb begin
    statusByte           = 8'h00;
    statusByte[ST_READY] = !busy;
    statusByte[ST_ERASE] = errErase;
    statusByte[ST_PROG]  = errProg;
    statusByte[ST_ABORT] = errAbort;
  end

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrEn));

  // R12
  ready_view_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (mode == M_STATUS));

  // R8
  abort_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(errErase) || $rose(errProg)) |-> errAbort);

  // R5
  one_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.prog, strb.erase, strb.clrLocks}));

endmodule

// File: rtl/fc_datapath.sv
module fc_datapath
  import flashcmd_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          BLK_W    = 5,
  parameter logic [7:0]  MFR_CODE = 8'h3C,
  parameter logic [7:0]  DEV_CODE = 8'hB1,
  parameter logic [(1<<(ADDR_W-BLK_W))-1:0] BLK_LOCK_INIT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  input  logic              masterLock,
  input  fcStrobe_t         strb,
  input  logic [7:0]        statusByte,
  output logic              targetLocked,
  output logic [7:0]        rdData
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BIDX_W = ADDR_W - BLK_W;
  localparam int NBLK   = 1 << BIDX_W;

  logic [7:0]        mem [DEPTH];
  logic [NBLK-1:0]   blkLock;
  logic [BIDX_W-1:0] tgtBlk;
  logic [BLK_W-1:0]  blkOff;
  logic [7:0]        curByte, idByte, viewByte;

  assign tgtBlk       = addr[ADDR_W-1:BLK_W];
  assign blkOff       = addr[BLK_W-1:0];
  assign targetLocked = blkLock[tgtBlk];
  assign curByte      = mem[addr];

  // one protection flop per block
  for (genvar b = 0; b < NBLK; b++) begin : g_lock
    logic lockQ;
    always_ff @(posedge clk) begin
      if (!rstN)              lockQ <= BLK_LOCK_INIT[b];
      else if (strb.clrLocks) lockQ <= 1'b0;
    end
    assign blkLock[b] = lockQ;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rstN)
        mem[i] <= 8'hFF;
      else if (strb.erase && ((i >> BLK_W) == int'(tgtBlk)))
        mem[i] <= 8'hFF;
      else if (strb.prog && (addr == ADDR_W'(i)))
        mem[i] <= mem[i] & wrData;
    end
  end

  always_comb begin
    if (addr == ADDR_W'(0))      idByte = MFR_CODE;
    else if (addr == ADDR_W'(1)) idByte = DEV_CODE;
    else if (addr == ADDR_W'(3)) idByte = {7'b0, masterLock};
    else if (blkOff == BLK_W'(2)) idByte = {7'b0, targetLocked};
    else                          idByte = 8'h00;
  end

  always_comb begin
    case (strb.view)
      VIEW_ARRAY: viewByte = curByte;
      VIEW_ID:    viewByte = idByte;
      default:    viewByte = statusByte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= 8'hFF;
    else if (rdEn) rdData <= viewByte;
  end

  // R5
  prog_and_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.prog |=> ((mem[$past(addr)] & ~$past(curByte)) == 8'h00));

  // R8
  prog_unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.prog || strb.erase) |-> !targetLocked);

  // R7
  unlock_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrLocks |=> (blkLock == '0));

  // R11
  busy_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !statusByte[ST_READY]) |=> (rdData == $past(statusByte)));

  // R13
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn && $past(rstN)) |=> $stable(rdData));

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flashcmd_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         BLK_W       = 5,
  parameter int         BUSY_CYCLES = 4,
  parameter logic [7:0] MFR_CODE    = 8'h3C,
  parameter logic [7:0] DEV_CODE    = 8'hB1,
  parameter logic [(1<<(ADDR_W-BLK_W))-1:0] BLK_LOCK_INIT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterLock,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [7:0]        rdData
);

  fcStrobe_t  strb;
  logic [7:0] statusByte;
  logic       targetLocked;

  fc_control #(
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .masterLock  (masterLock),
    .targetLocked(targetLocked),
    .strb        (strb),
    .statusByte  (statusByte)
  );

  fc_datapath #(
    .ADDR_W       (ADDR_W),
    .BLK_W        (BLK_W),
    .MFR_CODE     (MFR_CODE),
    .DEV_CODE     (DEV_CODE),
    .BLK_LOCK_INIT(BLK_LOCK_INIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .addr        (addr),
    .wrData      (wrData),
    .rdEn        (rdEn),
    .masterLock  (masterLock),
    .strb        (strb),
    .statusByte  (statusByte),
    .targetLocked(targetLocked),
    .rdData      (rdData)
  );

endmodule

// File: tb/flash_cmd_if_test.sv
`timescale 1ns/1ps
module flash_cmd_if_test;

  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_IDLE = 2'd2;
  localparam int NV = 62;

  // {kind, addr, data-or-expected-or-idle-count}
  localparam logic [17:0] VECS [NV] = '{
    {K_RD, 8'h10, 8'hFF},                        // R1 reset array
    {K_WR, 8'h00, 8'h90},                        // R3
    {K_RD, 8'h00, 8'h3C}, {K_RD, 8'h01, 8'hB1},  // R3 codes
    {K_RD, 8'h03, 8'h00}, {K_RD, 8'h42, 8'h01},  // R3 master, block lock
    {K_RD, 8'h22, 8'h00}, {K_RD, 8'h05, 8'h00},  // R3 other
    {K_WR, 8'h00, 8'hFF}, {K_RD, 8'h00, 8'hFF},  // R2
    {K_WR, 8'h10, 8'h40}, {K_WR, 8'h10, 8'hA5},  // R5
    {K_RD, 8'h10, 8'h00},                        // R11 busy status
    {K_IDLE, 8'h00, 8'h03},
    {K_RD, 8'h10, 8'h80},                        // R11 ready, R12 view
    {K_WR, 8'h00, 8'hFF}, {K_RD, 8'h10, 8'hA5},  // R2 R5
    {K_WR, 8'h10, 8'h40}, {K_WR, 8'h10, 8'h3C},  // R5 AND
    {K_IDLE, 8'h00, 8'h04},
    {K_WR, 8'h00, 8'hFF}, {K_RD, 8'h10, 8'h24},  // R5
    {K_WR, 8'h30, 8'h40}, {K_WR, 8'h30, 8'h5A},
    {K_IDLE, 8'h00, 8'h04},
    {K_WR, 8'h00, 8'h70}, {K_RD, 8'h00, 8'h80},  // R4
    {K_WR, 8'h45, 8'h40}, {K_WR, 8'h45, 8'h00},  // R8 locked program
    {K_RD, 8'h45, 8'h92},                        // R8 R12
    {K_WR, 8'h00, 8'hFF}, {K_RD, 8'h45, 8'hFF},  // R8 unchanged
    {K_WR, 8'h00, 8'h50},                        // R10
    {K_WR, 8'h00, 8'h70}, {K_RD, 8'h00, 8'h80},  // R10
    {K_WR, 8'h40, 8'h20}, {K_WR, 8'h40, 8'hD0},  // R8 locked erase
    {K_RD, 8'h40, 8'hA2},
    {K_WR, 8'h00, 8'h50},
    {K_WR, 8'h10, 8'h20}, {K_WR, 8'h10, 8'h33},  // R9 bad confirm
    {K_RD, 8'h10, 8'hA2},
    {K_WR, 8'h00, 8'h50},
    {K_WR, 8'h00, 8'hFF}, {K_RD, 8'h10, 8'h24},  // R9 unchanged
    {K_WR, 8'h08, 8'h20}, {K_WR, 8'h1F, 8'hD0},  // R6
    {K_IDLE, 8'h00, 8'h04},
    {K_WR, 8'h00, 8'hFF}, {K_RD, 8'h10, 8'hFF},  // R6 erased
    {K_RD, 8'h30, 8'h5A},                        // R6 other block kept
    {K_WR, 8'h00, 8'h60}, {K_WR, 8'h00, 8'hD0},  // R7
    {K_IDLE, 8'h00, 8'h04},
    {K_WR, 8'h00, 8'h90}, {K_RD, 8'h42, 8'h00},  // R7 cleared
    {K_WR, 8'h00, 8'hFF},
    {K_WR, 8'h45, 8'h40}, {K_WR, 8'h45, 8'h0F},  // R7 R5
    {K_IDLE, 8'h00, 8'h04},
    {K_WR, 8'h00, 8'hFF}, {K_RD, 8'h45, 8'h0F}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       masterLock = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_if #(
    .ADDR_W(8), .BLK_W(5), .BUSY_CYCLES(4),
    .MFR_CODE(8'h3C), .DEV_CODE(8'hB1), .BLK_LOCK_INIT(8'b0000_0100)
  ) uut (
    .clk(clk), .rstN(rstN), .masterLock(masterLock), .addr(addr),
    .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; v = rdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset: status reads ready with no errors
    wr(8'h00, 8'h70); rd(8'h00, v); check("R1 status after reset", v, 8'h80);
    wr(8'h00, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i][17:16])
        K_WR:    wr(VECS[i][15:8], VECS[i][7:0]);
        K_RD: begin
          rd(VECS[i][15:8], v);
          check($sformatf("vector %0d", i), v, VECS[i][7:0]);
        end
        default: idle(int'(VECS[i][7:0]));
      endcase
    end

    // R1 mid-run reset restores array and protection
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rd(8'h45, v); check("R1 array after reset", v, 8'hFF);
    wr(8'h00, 8'h90); rd(8'h42, v); check("R1 lock after reset", v, 8'h01);

    // R7 master lock blocks unlock
    masterLock = 1'b1;
    wr(8'h00, 8'h60); wr(8'h00, 8'hD0);
    rd(8'h00, v); check("R7 unlock refused", v, 8'hA2);
    wr(8'h00, 8'h90); rd(8'h03, v); check("R3 master bit", v, 8'h01);
    rd(8'h42, v); check("R7 lock kept", v, 8'h01);
    masterLock = 1'b0;
    wr(8'h00, 8'h50);

    // R9 unlock setup without confirm
    wr(8'h00, 8'h60); wr(8'h00, 8'h11);
    rd(8'h00, v); check("R9 unlock bad confirm", v, 8'hA2);
    wr(8'h00, 8'h90); rd(8'h42, v); check("R9 lock kept", v, 8'h01);
    wr(8'h00, 8'h50);

    // R11 write during busy is dropped
    wr(8'h00, 8'hFF);
    wr(8'h31, 8'h40); wr(8'h31, 8'hF0);
    wr(8'h00, 8'h90);
    idle(4);
    rd(8'h00, v); check("R11 busy write ignored", v, 8'h80);
    wr(8'h00, 8'hFF); rd(8'h31, v); check("R5 program block1", v, 8'hF0);

    // R13 read and command write on the same edge
    @(negedge clk); addr = 8'h31; rdEn = 1'b1; wrEn = 1'b1; wrData = 8'h90;
    @(negedge clk); rdEn = 1'b0; wrEn = 1'b0; v = rdData;
    check("R13 same-edge old view", v, 8'hF0);
    rd(8'h00, v); check("R13 new view", v, 8'h3C);
    idle(2); check("R13 hold", rdData, 8'h3C);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule